// File: doc/BRIEF.md
# Four-Slot Segment Page Mapper

This block widens a 16-bit processor address into a 22-bit physical address. The processor space is cut into four 16 KB windows. Address bits [15:14] pick the window, and each window has its own 8-bit segment register. The physical address is the chosen segment placed above the 14-bit offset. The processor loads and reads back the segment registers through four I/O ports, one per window, at 0xB0 + window.

For the segment currently addressed, the mapper also gives a region class: ROM, installed RAM, or nothing. ROM banks start at segments 0, 16, 32 and 48, and each bank covers only as many segments as its parameterised size. Installed RAM is packed against the top of the 256-segment space, so its lowest segment depends on the installed size. The highest four segments are also marked as video memory, which a bus-wait arbiter needs to know. The mapper gates the memory write strobe so that only RAM can be written. On reads from an empty segment it forces the returned data to 0xFF. The memory arrays are outside this block.

Top module: `page_mapper`

## Requirements
- R1: `phys_addr` is {segment register of window `cpu_addr[15:14]`, `cpu_addr[13:0]`}, and each window uses only its own register.
- R2: An I/O write (`io_wr` high at a rising edge) to port 0xB0+n loads `io_wdata` into the register of window n. The new value drives `phys_addr` from the next cycle on.
- R3: `io_rdata` shows the register of window n while `io_port` is 0xB0+n, and shows 0xFF for every other port value.
- R4: Reset (`rst_n` low, asynchronous) clears all four segment registers to 0x00.
- R5: A segment s is ROM (`mem_class` = 2'b00) when s is below 64 and (s mod 16) is below the size of bank s/16. The bank sizes default to 4, 2, 1 and 1 segments for banks 0 to 3. ROM takes priority over RAM.
- R6: A segment s that is not ROM is RAM (`mem_class` = 2'b01) when s is at least 256 − RAM_KB/16. With the default of 128 KB, that is segments 0xF8 and above.
- R7: All other segments are unmapped (`mem_class` = 2'b10). While the current segment is unmapped, `cpu_rdata` is 0xFF. Otherwise `cpu_rdata` equals `mem_rdata`.
- R8: `mem_we` equals `cpu_wr` when the current segment is RAM, and is 0 for ROM or unmapped segments.
- R9: `video_page` is 1 exactly when the current segment is 0xFC to 0xFF. RAM_KB must be at least 64.
- R10: I/O writes to any port other than 0xB0 to 0xB3 leave all four segment registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| io_port | input | 8 | I/O port number |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data (segment readback or 0xFF) |
| cpu_addr | input | 16 | Processor memory address |
| cpu_wr | input | 1 | Processor memory write request |
| mem_rdata | input | 8 | Read data from the memory arrays |
| cpu_rdata | output | 8 | Read data returned to the processor |
| phys_addr | output | 22 | Physical address |
| mem_class | output | 2 | Region class: 00 ROM, 01 RAM, 10 unmapped |
| mem_we | output | 1 | Gated memory write enable |
| video_page | output | 1 | Current segment is video memory |

## Verification
The bench loads all 256 segment values into each of the four windows and checks every output against an arithmetic model. It also moves the offset in step with the segment value, so that a swapped or truncated address field shows up as a mismatch. The sweep covers every boundary of the three-way classification: the edges of each ROM bank, the RAM floor, and the video boundary. It therefore separates off-by-one errors in bank sizes or floors from a wrong priority. A second pattern loads a different value into each window and addresses every window in turn. This shows whether windows leak into one another. A third pattern writes to non-mapper ports, including neighbours of 0xB0 to 0xB3 that differ in one bit. It then reads the registers back, which separates a full port decode from a partial one.

// File: rtl/mapper_pkg.sv
package mapper_pkg;

    typedef enum logic [1:0] {
        SEG_ROM  = 2'b00,
        SEG_RAM  = 2'b01,
        SEG_NONE = 2'b10
    } seg_class_e;

    localparam int BANK_CNT_W = 5;

endpackage

// File: rtl/map_seg_regs.sv
module map_seg_regs #(
    parameter int                SLOTS     = 4,
    parameter int                SEG_W     = 8,
    parameter int                PORT_W    = 8,
    parameter logic [PORT_W-1:0] PORT_BASE = 8'hB0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        io_wr,
    input  logic [PORT_W-1:0]           io_port,
    input  logic [SEG_W-1:0]            io_wdata,
    output logic [SEG_W-1:0]            io_rdata,
    output logic [SLOTS-1:0][SEG_W-1:0] seg_q
);
    localparam int SEL_W = $clog2(SLOTS);

    logic             port_hit;
    logic [SEL_W-1:0] port_sel;

    // Registers occupy an aligned group of ports; upper bits must match fully.
    assign port_hit = (io_port[PORT_W-1:SEL_W] == PORT_BASE[PORT_W-1:SEL_W]);
    assign port_sel = io_port[SEL_W-1:0];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                seg_q[g] <= '0;
            end else if (io_wr && port_hit && (port_sel == SEL_W'(g))) begin
                seg_q[g] <= io_wdata;
            end
        end
    end

    always_comb begin
        io_rdata = '1;
        if (port_hit) begin
            io_rdata = seg_q[port_sel];
        end
    end

endmodule

// File: rtl/map_seg_class.sv
module map_seg_class
    import mapper_pkg::*;
#(
    parameter int                             SEG_W         = 8,
    parameter int                             PAGE_KB       = 16,
    parameter int                             RAM_KB        = 128,
    parameter int                             VIDEO_KB      = 64,
    parameter int                             ROM_BANKS     = 4,
    parameter int                             BANK_STRIDE   = 16,
    parameter logic [ROM_BANKS*BANK_CNT_W-1:0] ROM_BANK_SEGS = {5'd1, 5'd1, 5'd2, 5'd4}
) (
    input  logic [SEG_W-1:0] seg,
    output seg_class_e       cls,
    output logic             video
);
    localparam int NSEG        = 1 << SEG_W;
    localparam int RAM_FLOOR   = NSEG - RAM_KB / PAGE_KB;
    localparam int VIDEO_FLOOR = NSEG - VIDEO_KB / PAGE_KB;

    logic [ROM_BANKS-1:0] rom_hit;
    logic                 ram_hit;
    logic [31:0]          seg_wide;

    assign seg_wide = 32'(seg);

    for (genvar b = 0; b < ROM_BANKS; b++) begin : g_bank
        localparam int LO  = b * BANK_STRIDE;
        localparam int CNT = int'(ROM_BANK_SEGS[b*BANK_CNT_W +: BANK_CNT_W]);
        logic [31:0] rel;
        // Unsigned wrap makes segments below the bank base fail the compare.
        assign rel        = seg_wide - 32'(LO);
        assign rom_hit[b] = (rel < 32'(CNT));
    end

    assign ram_hit = (seg_wide >= 32'(RAM_FLOOR));

    always_comb begin
        if (|rom_hit) begin
            cls = SEG_ROM;
        end else if (ram_hit) begin
            cls = SEG_RAM;
        end else begin
            cls = SEG_NONE;
        end
    end

    assign video = (cls == SEG_RAM) && (seg_wide >= 32'(VIDEO_FLOOR));

endmodule

// File: rtl/page_mapper.sv
module page_mapper
    import mapper_pkg::*;
#(
    parameter int                          ADDR_W        = 16,
    parameter int                          SLOTS         = 4,
    parameter int                          SEG_W         = 8,
    parameter int                          RAM_KB        = 128,
    parameter int                          VIDEO_KB      = 64,
    parameter logic [4*BANK_CNT_W-1:0]     ROM_BANK_SEGS = {5'd1, 5'd1, 5'd2, 5'd4},
    parameter int                          DATA_W        = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  io_wr,
    input  logic [7:0]            io_port,
    input  logic [SEG_W-1:0]      io_wdata,
    output logic [SEG_W-1:0]      io_rdata,
    input  logic [ADDR_W-1:0]     cpu_addr,
    input  logic                  cpu_wr,
    input  logic [DATA_W-1:0]     mem_rdata,
    output logic [DATA_W-1:0]     cpu_rdata,
    output logic [SEG_W+ADDR_W-$clog2(SLOTS)-1:0] phys_addr,
    output logic [1:0]            mem_class,
    output logic                  mem_we,
    output logic                  video_page
);
    localparam int SEL_W   = $clog2(SLOTS);
    localparam int OFF_W   = ADDR_W - SEL_W;
    localparam int PAGE_KB = (1 << OFF_W) / 1024;

    logic [SLOTS-1:0][SEG_W-1:0] seg_q;
    logic [SEL_W-1:0]            slot;
    logic [SEG_W-1:0]            cur_seg;
    seg_class_e                  cur_cls;
    logic                        cur_video;

    map_seg_regs #(
        .SLOTS    (SLOTS),
        .SEG_W    (SEG_W),
        .PORT_W   (8),
        .PORT_BASE(8'hB0)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .io_wr   (io_wr),
        .io_port (io_port),
        .io_wdata(io_wdata),
        .io_rdata(io_rdata),
        .seg_q   (seg_q)
    );

    assign slot    = cpu_addr[ADDR_W-1 -: SEL_W];
    assign cur_seg = seg_q[slot];

    map_seg_class #(
        .SEG_W        (SEG_W),
        .PAGE_KB      (PAGE_KB),
        .RAM_KB       (RAM_KB),
        .VIDEO_KB     (VIDEO_KB),
        .ROM_BANKS    (4),
        .BANK_STRIDE  (16),
        .ROM_BANK_SEGS(ROM_BANK_SEGS)
    ) u_class (
        .seg  (cur_seg),
        .cls  (cur_cls),
        .video(cur_video)
    );

    assign phys_addr  = {cur_seg, cpu_addr[OFF_W-1:0]};
    assign mem_class  = cur_cls;
    assign mem_we     = cpu_wr && (cur_cls == SEG_RAM);
    assign video_page = cur_video;
    assign cpu_rdata  = (cur_cls == SEG_NONE) ? {DATA_W{1'b1}} : mem_rdata;

endmodule

// File: rtl/page_mapper_chk.sv
module page_mapper_chk #(
    parameter int SEG_W = 8,
    parameter int OFF_W = 14
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   io_wr,
    input logic [7:0]             io_port,
    input logic [SEG_W-1:0]       io_wdata,
    input logic [SEG_W-1:0]       io_rdata,
    input logic [OFF_W+1:0]       cpu_addr,
    input logic [7:0]             cpu_rdata,
    input logic [SEG_W+OFF_W-1:0] phys_addr,
    input logic [1:0]             mem_class,
    input logic                   mem_we,
    input logic                   video_page
);
    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (phys_addr[SEG_W+OFF_W-1:OFF_W] == '0)); // R4

    AST_SEG_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(io_wr && (io_port[7:2] == 6'b101100) && (io_port[1:0] == cpu_addr[OFF_W+1:OFF_W]))
         && $stable(cpu_addr))
        |-> (phys_addr[SEG_W+OFF_W-1:OFF_W] == $past(io_wdata))); // R2

    AST_OTHER_PORT_FF: assert property (@(posedge clk) disable iff (!rst_n)
        (io_port[7:2] != 6'b101100) |-> (io_rdata == '1)); // R3

    AST_UNMAPPED_FF: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_class == 2'b10) |-> (cpu_rdata == 8'hFF)); // R7

    AST_WE_ONLY_RAM: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_class == 2'b01)); // R8

    AST_VIDEO_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        video_page |-> ((mem_class == 2'b01) && (&phys_addr[SEG_W+OFF_W-1:OFF_W+2]))); // R9

endmodule

bind page_mapper page_mapper_chk #(
    .SEG_W(SEG_W),
    .OFF_W(OFF_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .io_wr     (io_wr),
    .io_port   (io_port),
    .io_wdata  (io_wdata),
    .io_rdata  (io_rdata),
    .cpu_addr  (cpu_addr),
    .cpu_rdata (cpu_rdata),
    .phys_addr (phys_addr),
    .mem_class (mem_class),
    .mem_we    (mem_we),
    .video_page(video_page)
);

// File: tb/page_mapper_tb.sv
`timescale 1ns/100ps
module page_mapper_tb;
    localparam int RAM_KB = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_port = 8'h00;
    logic [7:0]  io_wdata = 8'h00;
    logic [7:0]  io_rdata;
    logic [15:0] cpu_addr = 16'h0000;
    logic        cpu_wr = 1'b0;
    logic [7:0]  mem_rdata = 8'h00;
    logic [7:0]  cpu_rdata;
    logic [21:0] phys_addr;
    logic [1:0]  mem_class;
    logic        mem_we;
    logic        video_page;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    page_mapper #(
        .RAM_KB       (RAM_KB),
        .ROM_BANK_SEGS({5'd1, 5'd1, 5'd2, 5'd4})
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .io_wr     (io_wr),
        .io_port   (io_port),
        .io_wdata  (io_wdata),
        .io_rdata  (io_rdata),
        .cpu_addr  (cpu_addr),
        .cpu_wr    (cpu_wr),
        .mem_rdata (mem_rdata),
        .cpu_rdata (cpu_rdata),
        .phys_addr (phys_addr),
        .mem_class (mem_class),
        .mem_we    (mem_we),
        .video_page(video_page)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int bank_size(input int b);
        case (b)
            0: return 4;
            1: return 2;
            default: return 1;
        endcase
    endfunction

    function automatic int exp_class(input int v);
        if (v < 64 && (v % 16) < bank_size(v / 16)) return 0;
        if (v >= 256 - RAM_KB / 16) return 1;
        return 2;
    endfunction

    task automatic io_write(input logic [7:0] port, input logic [7:0] data);
        @(negedge clk);
        io_wr = 1'b1; io_port = port; io_wdata = data;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    initial begin
        #500000;
        failures++;
        $display("FAIL watchdog: run did not complete");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R4: all registers clear after reset
        for (int s = 0; s < 4; s++) begin
            io_port = 8'hB0 + 8'(s);
            cpu_addr = {2'(s), 14'h1234};
            #1;
            check("R4 readback after reset", 32'(io_rdata), 32'h0);
            check("R4 phys after reset", 32'(phys_addr), 32'h1234);
        end

        // Exhaustive sweep: every segment value in every window
        for (int s = 0; s < 4; s++) begin
            for (int v = 0; v < 256; v++) begin
                logic [13:0] off;
                int ec;
                off = 14'((v * 61 + s * 977) & 16'h3FFF);
                io_write(8'hB0 + 8'(s), 8'(v));
                io_port = 8'hB0 + 8'(s);
                cpu_addr = {2'(s), off};
                cpu_wr = v[0];
                mem_rdata = 8'h5A ^ 8'(v);
                #1;
                ec = exp_class(v);
                check("R3 readback", 32'(io_rdata), 32'(v));
                check("R1/R2 phys_addr", 32'(phys_addr), (32'(v) << 14) | 32'(off));
                check("R5/R6/R7 class", 32'(mem_class), 32'(ec));
                check("R8 mem_we", 32'(mem_we), (ec == 1) ? 32'(v[0]) : 32'h0);
                check("R7 cpu_rdata", 32'(cpu_rdata), (ec == 2) ? 32'hFF : 32'(8'h5A ^ 8'(v)));
                check("R9 video_page", 32'(video_page), (v >= 252) ? 32'h1 : 32'h0);
            end
        end

        // R1: distinct values per window, no leakage between windows
        io_write(8'hB0, 8'h11);
        io_write(8'hB1, 8'hF9);
        io_write(8'hB2, 8'h05);
        io_write(8'hB3, 8'hFE);
        for (int s = 0; s < 4; s++) begin
            logic [7:0] e;
            e = (s == 0) ? 8'h11 : (s == 1) ? 8'hF9 : (s == 2) ? 8'h05 : 8'hFE;
            cpu_addr = {2'(s), 14'h2AAA};
            #1;
            check("R1 window select", 32'(phys_addr), (32'(e) << 14) | 32'h2AAA);
        end

        // R10: writes to other ports leave registers unchanged
        io_write(8'hB4, 8'hAA);
        io_write(8'hB8, 8'hAA);
        io_write(8'hA0, 8'hAA);
        io_write(8'h30, 8'hAA);
        io_write(8'hF0, 8'hAA);
        for (int s = 0; s < 4; s++) begin
            logic [7:0] e;
            e = (s == 0) ? 8'h11 : (s == 1) ? 8'hF9 : (s == 2) ? 8'h05 : 8'hFE;
            io_port = 8'hB0 + 8'(s);
            cpu_addr = {2'(s), 14'h0001};
            #1;
            check("R10 readback unchanged", 32'(io_rdata), 32'(e));
            check("R10 phys unchanged", 32'(phys_addr), (32'(e) << 14) | 32'h1);
        end

        // R3: every non-mapper port reads 0xFF
        for (int p = 0; p < 256; p++) begin
            if (p < 8'hB0 || p > 8'hB3) begin
                io_port = 8'(p);
                #1;
                check("R3 other port reads FF", 32'(io_rdata), 32'hFF);
            end
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule